// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

This block is a watchdog timer that escalates in two steps. Software reaches it through one simple 32-bit register bus, which carries two 4 KB frames, each with its own select. The kick frame only re-arms the timer. The control frame holds the enable, the status flags, the timeout interval and the 64-bit deadline. The block watches a free-running 64-bit system count that comes in from outside.

When the count reaches the deadline while the block is enabled, the warning output rises first and a new deadline is set one interval later. If no kick arrives before that second deadline, the final output rises. The final output is meant for a reset or escalation controller. A kick, a new interval, or turning the enable on sets the deadline to the current count plus the interval and clears both stages.

Software should bring the block up in this order: clear the control register, write the interval, set the enable, then kick.

Top module: `wdog_twostage`

## Requirements
- R1: A write of any data to offset 0x000 of the kick frame sets the deadline to count + interval and clears both stage flags on the next clock edge.
- R2: Control frame offset 0x000 reads {29'b0, final flag (bit 2), warning flag (bit 1), enable (bit 0)}. Writes update only bit 0. Bits 1 and 2 cannot be set or cleared by a write that leaves the block enabled.
- R3: A write to control offset 0x008 stores the 32-bit interval, which reads back there. The same write sets the deadline to count + new interval and clears both flags.
- R4: A control write that moves the enable from 0 to 1 sets the deadline to count + interval and clears both flags.
- R5: While enabled with the warning flag clear, a count greater than or equal to the deadline sets the warning flag. On the same edge the deadline is reloaded as count + interval.
- R6: While enabled with the warning flag set, a count greater than or equal to the deadline sets the final flag. The final flag is never set unless the warning flag is set.
- R7: While disabled (enable written 0), both flags and both outputs stay at 0 whatever the count.
- R8: The deadline's low word (control 0x010) and high word (control 0x014) can be written directly and read back. Such a write overrides any computed value.
- R9: Offset 0xFCC returns a fixed, parameterised identification word: one value in the control frame and another in the kick frame.
- R10: Reads of any other offset, or with no select, return 0. Writes to any other offset, or with both selects high, change nothing.
- R11: A kick in the same cycle as an expiry wins: the flags stay clear and the deadline becomes count + interval.
- R12: Reset leaves the block disabled, with both flags, the interval and the deadline at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick_sel_i | input | 1 | Selects the kick frame |
| ctrl_sel_i | input | 1 | Selects the control frame |
| wr_en_i | input | 1 | Write strobe (read when low) |
| addr_i | input | 12 | Byte offset inside the selected frame |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from the selects and offset |
| syscnt_i | input | 64 | Free-running system count |
| warn_o | output | 1 | First-stage warning level |
| final_o | output | 1 | Second-stage escalation level |

## Verification
A kick can arrive on exactly the edge where the count reaches the deadline, so the re-arm path and the expiry path both claim the deadline and the flags in one cycle. The bench provokes this by setting the count equal to the pending deadline in the cycle of the kick write. It then checks that the warning output stays low and that the new deadline is exactly one interval past the kick count, with the warning rising only when the count reaches that value. An interval write that lands on a pending warning is judged the same way.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int unsigned ADDR_W = 12;

   localparam logic [ADDR_W-1:0] KICK_OFS   = 12'h000;
   localparam logic [ADDR_W-1:0] CSR_OFS    = 12'h000;
   localparam logic [ADDR_W-1:0] IVAL_OFS   = 12'h008;
   localparam logic [ADDR_W-1:0] DL_LO_OFS  = 12'h010;
   localparam logic [ADDR_W-1:0] DL_HI_OFS  = 12'h014;
   localparam logic [ADDR_W-1:0] IDENT_OFS  = 12'hFCC;

   typedef struct packed {
      logic kick;
      logic csr;
      logic ival;
      logic dl_lo;
      logic dl_hi;
   } wr_strobe_t;
endpackage

// File: rtl/wdog_decode.sv
module wdog_decode
   import wdog_pkg::*;
(
   input  logic              kick_sel,
   input  logic              ctrl_sel,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output wr_strobe_t        stb
);
   always_comb begin
      stb = '0;
      if (wr_en && kick_sel && !ctrl_sel && addr == KICK_OFS)
         stb.kick = 1'b1;
      if (wr_en && ctrl_sel && !kick_sel) begin
         case (addr)
            CSR_OFS:   stb.csr   = 1'b1;
            IVAL_OFS:  stb.ival  = 1'b1;
            DL_LO_OFS: stb.dl_lo = 1'b1;
            DL_HI_OFS: stb.dl_hi = 1'b1;
            default:   ;
         endcase
      end
   end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
   import wdog_pkg::*;
#(
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned IVAL_W  = 32,
   parameter int unsigned DATA_W  = 32,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wr_strobe_t        stb,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  cnt,
   output logic              en_q,
   output logic              warn_q,
   output logic              fin_q,
   output logic [IVAL_W-1:0] ival_q,
   output logic [CNT_W-1:0]  dl_q,
   output logic              warn_o,
   output logic              final_o
);
   localparam int unsigned HI_W = CNT_W - DATA_W;

   logic [IVAL_W-1:0] ival_src;
   logic [CNT_W-1:0]  rearm_val;
   logic              rearm;
   logic              disarm;
   logic              expire;

   assign ival_src  = stb.ival ? wdata[IVAL_W-1:0] : ival_q;
   assign rearm_val = cnt + CNT_W'(ival_src);
   assign rearm     = stb.kick | stb.ival | (stb.csr & wdata[0] & ~en_q);
   assign disarm    = stb.csr & ~wdata[0];
   assign expire    = en_q & (cnt >= dl_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         warn_q <= 1'b0;
         fin_q  <= 1'b0;
         ival_q <= '0;
         dl_q   <= '0;
      end else begin
         if (stb.csr)  en_q   <= wdata[0];
         if (stb.ival) ival_q <= wdata[IVAL_W-1:0];
         if (disarm) begin
            warn_q <= 1'b0;
            fin_q  <= 1'b0;
         end else if (rearm) begin
            dl_q   <= rearm_val;
            warn_q <= 1'b0;
            fin_q  <= 1'b0;
         end else if (expire) begin
            if (!warn_q) begin
               warn_q <= 1'b1;
               dl_q   <= rearm_val;
            end else begin
               fin_q  <= 1'b1;
            end
         end
         if (stb.dl_lo) dl_q[DATA_W-1:0]     <= wdata;
         if (stb.dl_hi) dl_q[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
      end
   end

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               warn_o  <= 1'b0;
               final_o <= 1'b0;
            end else begin
               warn_o  <= warn_q;
               final_o <= fin_q;
            end
         end
      end else begin : g_out_direct
         assign warn_o  = warn_q;
         assign final_o = fin_q;
      end
   endgenerate

   // R7: no flag may be live while the enable is off
   assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (!warn_q && !fin_q));

   // R6: escalation order
   assert_stage_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fin_q |-> warn_q);

   // R1 and R11: a kick always clears both stages
   assert_kick_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stb.kick |=> (!warn_q && !fin_q));

   // R3: interval write lands in the register
   assert_ival_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stb.ival |=> ival_q == $past(wdata[IVAL_W-1:0]));

   // R5: first expiry raises warning and pushes the deadline one interval on
   assert_first_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !warn_q && cnt >= dl_q && !stb.kick && !stb.ival && !stb.csr
       && !stb.dl_lo && !stb.dl_hi)
      |=> (warn_q && dl_q == $past(cnt) + CNT_W'($past(ival_q))));
endmodule

// File: rtl/wdog_rdmux.sv
module wdog_rdmux
   import wdog_pkg::*;
#(
   parameter int unsigned    CNT_W      = 64,
   parameter int unsigned    IVAL_W     = 32,
   parameter int unsigned    DATA_W     = 32,
   parameter logic [31:0]    ID_CONTROL = 32'h0D06_2C01,
   parameter logic [31:0]    ID_KICK    = 32'h0D06_2C02
) (
   input  logic              kick_sel,
   input  logic              ctrl_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic              en_q,
   input  logic              warn_q,
   input  logic              fin_q,
   input  logic [IVAL_W-1:0] ival_q,
   input  logic [CNT_W-1:0]  dl_q,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      rdata = '0;
      if (ctrl_sel && !kick_sel) begin
         case (addr)
            CSR_OFS:   rdata = DATA_W'({fin_q, warn_q, en_q});
            IVAL_OFS:  rdata = DATA_W'(ival_q);
            DL_LO_OFS: rdata = dl_q[DATA_W-1:0];
            DL_HI_OFS: rdata = DATA_W'(dl_q[CNT_W-1:DATA_W]);
            IDENT_OFS: rdata = DATA_W'(ID_CONTROL);
            default:   rdata = '0;
         endcase
      end else if (kick_sel && !ctrl_sel) begin
         if (addr == IDENT_OFS) rdata = DATA_W'(ID_KICK);
      end
   end
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
   import wdog_pkg::*;
#(
   parameter int unsigned CNT_W      = 64,
   parameter int unsigned IVAL_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter bit          OUT_REG    = 1'b0,
   parameter logic [31:0] ID_CONTROL = 32'h0D06_2C01,
   parameter logic [31:0] ID_KICK    = 32'h0D06_2C02
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kick_sel_i,
   input  logic              ctrl_sel_i,
   input  logic              wr_en_i,
   input  logic [11:0]       addr_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   input  logic [63:0]       syscnt_i,
   output logic              warn_o,
   output logic              final_o
);
   generate
      if (DATA_W != 32) begin : g_chk_data
         $error("wdog_twostage: bus data must be 32 bits");
      end
      if (CNT_W != 2 * DATA_W) begin : g_chk_cnt
         $error("wdog_twostage: count must be two bus words wide");
      end
      if (IVAL_W > DATA_W || IVAL_W == 0) begin : g_chk_ival
         $error("wdog_twostage: interval must fit in one bus word");
      end
   endgenerate

   wr_strobe_t        stb;
   logic              en_q, warn_q, fin_q;
   logic [IVAL_W-1:0] ival_q;
   logic [CNT_W-1:0]  dl_q;

   wdog_decode i_decode (
      .kick_sel (kick_sel_i),
      .ctrl_sel (ctrl_sel_i),
      .wr_en    (wr_en_i),
      .addr     (addr_i),
      .stb      (stb)
   );

   wdog_core #(
      .CNT_W   (CNT_W),
      .IVAL_W  (IVAL_W),
      .DATA_W  (DATA_W),
      .OUT_REG (OUT_REG)
   ) i_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (stb),
      .wdata   (wdata_i),
      .cnt     (syscnt_i),
      .en_q    (en_q),
      .warn_q  (warn_q),
      .fin_q   (fin_q),
      .ival_q  (ival_q),
      .dl_q    (dl_q),
      .warn_o  (warn_o),
      .final_o (final_o)
   );

   wdog_rdmux #(
      .CNT_W      (CNT_W),
      .IVAL_W     (IVAL_W),
      .DATA_W     (DATA_W),
      .ID_CONTROL (ID_CONTROL),
      .ID_KICK    (ID_KICK)
   ) i_rdmux (
      .kick_sel (kick_sel_i),
      .ctrl_sel (ctrl_sel_i),
      .addr     (addr_i),
      .en_q     (en_q),
      .warn_q   (warn_q),
      .fin_q    (fin_q),
      .ival_q   (ival_q),
      .dl_q     (dl_q),
      .rdata    (rdata_o)
   );
endmodule

// File: tb/test_wdog_twostage.sv
module test_wdog_twostage;
   localparam time         CLK_PERIOD = 10ns;
   localparam logic [31:0] IDC = 32'h0D06_2C01;
   localparam logic [31:0] IDK = 32'h0D06_2C02;

   localparam logic [2:0] NOP = 3'd0, WC = 3'd1, WK = 3'd2, RC = 3'd3, RK = 3'd4;

   typedef struct packed {
      logic [2:0]  op;
      logic [11:0] addr;
      logic [31:0] data;
      logic [63:0] cnt;
      logic        s1;
      logic        s2;
      logic        chk;
      logic [31:0] rd;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 43;
   localparam vec_t TBL [NV] = '{
      '{WC,  12'h000, 32'd0,      64'd0,      1'b0, 1'b0, 1'b0, 32'd0,   8'd2},  // R2 clear
      '{WC,  12'h008, 32'd100,    64'd10,     1'b0, 1'b0, 1'b0, 32'd0,   8'd3},  // R3 interval
      '{RC,  12'h008, 32'd0,      64'd11,     1'b0, 1'b0, 1'b1, 32'd100, 8'd3},  // R3 readback
      '{WC,  12'h000, 32'd1,      64'd20,     1'b0, 1'b0, 1'b0, 32'd0,   8'd4},  // R4 enable
      '{RC,  12'h010, 32'd0,      64'd21,     1'b0, 1'b0, 1'b1, 32'd120, 8'd4},  // R4 deadline
      '{WK,  12'h000, 32'hDEAD,   64'd30,     1'b0, 1'b0, 1'b0, 32'd0,   8'd1},  // R1 kick
      '{RC,  12'h010, 32'd0,      64'd40,     1'b0, 1'b0, 1'b1, 32'd130, 8'd1},  // R1 deadline
      '{NOP, 12'h000, 32'd0,      64'd129,    1'b0, 1'b0, 1'b0, 32'd0,   8'd5},  // R5 before
      '{NOP, 12'h000, 32'd0,      64'd130,    1'b1, 1'b0, 1'b0, 32'd0,   8'd5},  // R5 expiry
      '{RC,  12'h010, 32'd0,      64'd131,    1'b1, 1'b0, 1'b1, 32'd230, 8'd5},  // R5 reload
      '{RC,  12'h000, 32'd0,      64'd131,    1'b1, 1'b0, 1'b1, 32'd3,   8'd2},  // R2 status
      '{NOP, 12'h000, 32'd0,      64'd229,    1'b1, 1'b0, 1'b0, 32'd0,   8'd6},  // R6 before
      '{NOP, 12'h000, 32'd0,      64'd230,    1'b1, 1'b1, 1'b0, 32'd0,   8'd6},  // R6 final
      '{RC,  12'h000, 32'd0,      64'd231,    1'b1, 1'b1, 1'b1, 32'd7,   8'd2},  // R2 both
      '{WK,  12'h000, 32'd0,      64'd240,    1'b0, 1'b0, 1'b0, 32'd0,   8'd1},  // R1 clears
      '{WC,  12'h014, 32'd1,      64'd241,    1'b0, 1'b0, 1'b0, 32'd0,   8'd8},  // R8 hi write
      '{RC,  12'h014, 32'd0,      64'd242,    1'b0, 1'b0, 1'b1, 32'd1,   8'd8},  // R8 hi read
      '{NOP, 12'h000, 32'd0,      64'd500,    1'b0, 1'b0, 1'b0, 32'd0,   8'd8},  // R8 override
      '{WC,  12'h010, 32'd600,    64'd501,    1'b0, 1'b0, 1'b0, 32'd0,   8'd8},  // R8 lo write
      '{WC,  12'h014, 32'd0,      64'd502,    1'b0, 1'b0, 1'b0, 32'd0,   8'd8},  // R8 hi zero
      '{RC,  12'h010, 32'd0,      64'd503,    1'b0, 1'b0, 1'b1, 32'd600, 8'd8},  // R8 lo read
      '{NOP, 12'h000, 32'd0,      64'd600,    1'b1, 1'b0, 1'b0, 32'd0,   8'd8},  // R8 expiry
      '{WC,  12'h000, 32'd0,      64'd601,    1'b0, 1'b0, 1'b0, 32'd0,   8'd7},  // R7 disable
      '{NOP, 12'h000, 32'd0,      64'd100000, 1'b0, 1'b0, 1'b0, 32'd0,   8'd7},  // R7 quiet
      '{RC,  12'h000, 32'd0,      64'd100000, 1'b0, 1'b0, 1'b1, 32'd0,   8'd7},  // R7 csr
      '{RK,  12'hFCC, 32'd0,      64'd100000, 1'b0, 1'b0, 1'b1, IDK,     8'd9},  // R9 kick id
      '{RC,  12'hFCC, 32'd0,      64'd100000, 1'b0, 1'b0, 1'b1, IDC,     8'd9},  // R9 ctrl id
      '{RK,  12'h000, 32'd0,      64'd100000, 1'b0, 1'b0, 1'b1, 32'd0,   8'd10}, // R10
      '{RC,  12'h004, 32'd0,      64'd100000, 1'b0, 1'b0, 1'b1, 32'd0,   8'd10}, // R10
      '{WC,  12'h020, 32'hFFFF,   64'd100001, 1'b0, 1'b0, 1'b0, 32'd0,   8'd10}, // R10
      '{RK,  12'h008, 32'd0,      64'd100001, 1'b0, 1'b0, 1'b1, 32'd0,   8'd10}, // R10
      '{WK,  12'h008, 32'd5,      64'd100001, 1'b0, 1'b0, 1'b0, 32'd0,   8'd10}, // R10
      '{RC,  12'h008, 32'd0,      64'd100002, 1'b0, 1'b0, 1'b1, 32'd100, 8'd10}, // R10 kept
      '{WC,  12'h000, 32'd1,      64'd200000, 1'b0, 1'b0, 1'b0, 32'd0,   8'd4},  // R4 re-enable
      '{NOP, 12'h000, 32'd0,      64'd200099, 1'b0, 1'b0, 1'b0, 32'd0,   8'd11}, // R11
      '{WK,  12'h000, 32'd0,      64'd200100, 1'b0, 1'b0, 1'b0, 32'd0,   8'd11}, // R11 collide
      '{NOP, 12'h000, 32'd0,      64'd200199, 1'b0, 1'b0, 1'b0, 32'd0,   8'd11}, // R11
      '{NOP, 12'h000, 32'd0,      64'd200200, 1'b1, 1'b0, 1'b0, 32'd0,   8'd11}, // R11 later
      '{WC,  12'h008, 32'd50,     64'd200250, 1'b0, 1'b0, 1'b0, 32'd0,   8'd3},  // R3 clears
      '{NOP, 12'h000, 32'd0,      64'd200299, 1'b0, 1'b0, 1'b0, 32'd0,   8'd3},  // R3
      '{NOP, 12'h000, 32'd0,      64'd200300, 1'b1, 1'b0, 1'b0, 32'd0,   8'd3},  // R3 new ival
      '{WC,  12'h000, 32'd7,      64'd200301, 1'b1, 1'b0, 1'b0, 32'd0,   8'd2},  // R2 ro bits
      '{RC,  12'h000, 32'd0,      64'd200302, 1'b1, 1'b0, 1'b1, 32'd3,   8'd2}   // R2 ro bits
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        kick_sel = 1'b0, ctrl_sel = 1'b0, wr_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [63:0] syscnt = '0;
   logic        warn, fin;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   wdog_twostage i_wdog_twostage (
      .clk        (clk),
      .rst_n      (rst_n),
      .kick_sel_i (kick_sel),
      .ctrl_sel_i (ctrl_sel),
      .wr_en_i    (wr_en),
      .addr_i     (addr),
      .wdata_i    (wdata),
      .rdata_o    (rdata),
      .syscnt_i   (syscnt),
      .warn_o     (warn),
      .final_o    (fin)
   );

   task automatic check(input bit ok, input int req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic rd_check(input logic ks, input logic cs, input logic [11:0] a,
                           input logic [31:0] exp, input int req);
      kick_sel = ks; ctrl_sel = cs; wr_en = 1'b0; addr = a;
      #1;
      check(rdata === exp, req, "read", 64'(rdata), 64'(exp));
      kick_sel = 1'b0; ctrl_sel = 1'b0;
   endtask

   task automatic step(input vec_t v);
      syscnt   = v.cnt;
      addr     = v.addr;
      wdata    = v.data;
      kick_sel = (v.op == WK || v.op == RK);
      ctrl_sel = (v.op == WC || v.op == RC);
      wr_en    = (v.op == WC || v.op == WK);
      #1;
      if (v.chk) check(rdata === v.rd, int'(v.req), "read", 64'(rdata), 64'(v.rd));
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; kick_sel = 1'b0; ctrl_sel = 1'b0;
      check(warn === v.s1 && fin === v.s2, int'(v.req), "stages",
            64'({warn, fin}), 64'({v.s1, v.s2}));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      check(warn === 1'b0 && fin === 1'b0, 12, "reset outputs", 64'({warn, fin}), 64'd0);
      rd_check(1'b0, 1'b1, 12'h000, 32'd0, 12);
      rd_check(1'b0, 1'b1, 12'h008, 32'd0, 12);
      rd_check(1'b0, 1'b1, 12'h010, 32'd0, 12);
      rd_check(1'b0, 1'b0, 12'hFCC, 32'd0, 10);  // R10 no select
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NV; i++) step(TBL[i]);
      // R10: both selects high, write ignored
      kick_sel = 1'b1; ctrl_sel = 1'b1; wr_en = 1'b1; addr = 12'h008; wdata = 32'd9;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
      rd_check(1'b0, 1'b1, 12'h008, 32'd50, 10);
      // R12: reset in the middle of a warning
      rst_n = 1'b0;
      #1;
      check(warn === 1'b0 && fin === 1'b0, 12, "mid reset", 64'({warn, fin}), 64'd0);
      rd_check(1'b0, 1'b1, 12'h000, 32'd0, 12);
      rd_check(1'b0, 1'b1, 12'h014, 32'd0, 12);
      @(negedge clk);
      rst_n = 1'b1;
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule